// File: doc/BRIEF.md
# NAND bus cycle timing generator

This block turns single bus-cycle requests into pin activity on an asynchronous NAND flash interface. An upstream port hands over one request at a time: a command byte, an address byte, or a data word to write or read. The block then drives chip enable, the command and address latch enables, the write and read strobes and the data bus. Every phase length is a clock count taken from configuration inputs, so the same logic serves devices of different speeds.

A request is taken when `req_valid` and `req_ready` are both high. One clock after the cycle completes, `done` pulses for one clock and `rdata` holds the captured read data. Chip enable stays low while requests keep arriving back to back. It is released as soon as the port is idle with no request waiting. Before a strobe the block inserts the turnaround gap that the previous cycle kind calls for. The bus carries either 8-bit or 16-bit data.

Top module: `nand_cycle_timer`

## Requirements
- R1: After reset `ce_n`, `we_n` and `re_n` are 1; `cle`, `ale`, `dq_oe` and `done` are 0; `req_ready` is 1.
- R2: A strobe stays low for t_lo clocks, with 0 counting as 1. It then stays high for t_hi clocks, with 0 counting as 1, before the cycle completes.
- R3: When chip enable was released, the first strobe falls t_cs clocks (0 counting as 1) after `ce_n` falls. A strobe is only ever low while `ce_n` is low.
- R4: A read latches `dq_i` at the clock edge that ends the t_acc-th clock (0 counting as 1) of the read strobe, counting the first low clock as 1. If that point lies beyond the low and high phases, the high phase is stretched until it is reached.
- R5: When a request is presented on the `done` cycle, the next strobe falls exactly t_hi + 1 + G clocks after the previous strobe rose. G is the gap count that applies, with 0 counting as 1; G is 0 when no gap applies. A data read following a strobe of any write kind other than an address cycle uses G = t_w2r.
- R6: After a read strobe, a following read uses G = t_r2r and any other cycle uses G = t_r2w.
- R7: A data cycle that follows an address cycle uses G = t_a2d. Consecutive address cycles have no gap.
- R8: `req_kind` 00 is a command cycle with `cle` high, and 01 is an address cycle with `ale` high. Kinds 10 and 11 are data cycles with neither latch enable high. `cle` and `ale` are never high together. Command and address bytes go out on `dq_o[7:0]` with `dq_o[15:8]` = 0, even in 16-bit mode.
- R9: In 8-bit mode, data writes drive `{8'h00, wdata[7:0]}` and reads return `{24'h0, dq_i[7:0]}`. In 16-bit mode (`wide16` = 1), writes drive `{wdata[23:16], wdata[7:0]}` and reads return `{8'h0, dq_i[15:8], 8'h0, dq_i[7:0]}`. `dq_oe` is high during write strobes and low during read strobes.
- R10: `ce_n` stays low across requests presented on each `done` cycle. It rises one clock after an idle cycle with no request. `done` is a one-clock pulse.
- R11: `we_n` and `re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock when valid |
| req_kind | input | 2 | 00 command, 01 address, 1x data |
| req_write | input | 1 | Data direction for data cycles (1 = write) |
| req_wdata | input | 32 | Command/address byte or write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Read data packed per width mode |
| t_lo | input | CW | Strobe low count |
| t_hi | input | CW | Strobe high count |
| t_acc | input | CW | Read sample point count |
| t_w2r | input | CW | Write-to-read gap |
| t_r2w | input | CW | Read-to-other gap |
| t_r2r | input | CW | Read-to-read gap |
| t_cs | input | CW | Chip-enable setup count |
| t_a2d | input | A2D_W | Address-to-data gap |
| wide16 | input | 1 | 16-bit data mode |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_o | output | 16 | Data bus out |
| dq_oe | output | 1 | Data bus output enable |
| dq_i | input | 16 | Data bus in |

## Verification
The turnaround gaps only show when a request arrives in the single idle clock that carries `done`. The bench therefore chains requests by raising `req_valid` on the same falling edge where it sees `done`, and measures the distance from strobe rise to strobe fall with a pin monitor. The read sample point is hard to see from outside. The bench drives `dq_i` with the index of the current clock since the read strobe fell, so the returned byte names the exact sampled clock. This also covers a sample point set past the end of the strobe.

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer #(
  parameter int CW    = 8,
  parameter int A2D_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic             req_write,
  input  logic [31:0]      req_wdata,
  output logic             done,
  output logic [31:0]      rdata,
  input  logic [CW-1:0]    t_lo,
  input  logic [CW-1:0]    t_hi,
  input  logic [CW-1:0]    t_acc,
  input  logic [CW-1:0]    t_w2r,
  input  logic [CW-1:0]    t_r2w,
  input  logic [CW-1:0]    t_r2r,
  input  logic [CW-1:0]    t_cs,
  input  logic [A2D_W-1:0] t_a2d,
  input  logic             wide16,
  output logic             ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [15:0]      dq_o,
  output logic             dq_oe,
  input  logic [15:0]      dq_i
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_GAP, S_LOW, S_HIGH} state_t;
  typedef enum logic [1:0] {L_NONE, L_WE, L_RE, L_ADDR} last_t;

  state_t          state_q;
  last_t           last_q;
  logic [CW-1:0]   cnt_q, acc_q;
  logic            sampled_q, rd_q;
  logic [1:0]      kind_q;
  logic [31:0]     wdata_q;
  logic            gap_need;
  logic [CW-1:0]   gap_val;

  function automatic logic [CW-1:0] nz(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  wire rd_in    = req_kind[1] && !req_write;
  wire strobing = (state_q == S_LOW) || (state_q == S_HIGH);
  wire acc_hit  = strobing && rd_q && !sampled_q && (acc_q == CW'(1));
  wire finish   = (state_q == S_HIGH) && (cnt_q == CW'(1)) &&
                  (!rd_q || sampled_q || acc_hit);

  always_comb begin
    gap_need = 1'b1;
    gap_val  = t_w2r;
    if (last_q == L_ADDR && req_kind[1]) gap_val = CW'(t_a2d);
    else if (last_q == L_RE)             gap_val = rd_in ? t_r2r : t_r2w;
    else if (last_q == L_WE && rd_in)    gap_val = t_w2r;
    else                                 gap_need = 1'b0;
  end

  assign req_ready = (state_q == S_IDLE);
  assign we_n  = !((state_q == S_LOW) && !rd_q);
  assign re_n  = !((state_q == S_LOW) && rd_q);
  assign cle   = strobing && (kind_q == 2'b00);
  assign ale   = strobing && (kind_q == 2'b01);
  assign dq_oe = strobing && !rd_q;
  assign dq_o  = (kind_q[1] && wide16) ? {wdata_q[23:16], wdata_q[7:0]}
                                       : {8'h00, wdata_q[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      last_q    <= L_NONE;
      cnt_q     <= '0;
      acc_q     <= '0;
      sampled_q <= 1'b0;
      rd_q      <= 1'b0;
      kind_q    <= 2'b00;
      wdata_q   <= '0;
      ce_n      <= 1'b1;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      if (acc_hit) begin
        sampled_q <= 1'b1;
        rdata     <= wide16 ? {8'h00, dq_i[15:8], 8'h00, dq_i[7:0]}
                            : {24'h0, dq_i[7:0]};
      end else if (strobing && rd_q && !sampled_q) begin
        acc_q <= acc_q - CW'(1);
      end
      unique case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            kind_q  <= req_kind;
            rd_q    <= rd_in;
            wdata_q <= req_wdata;
            if (ce_n) begin
              ce_n    <= 1'b0;
              state_q <= S_SETUP;
              cnt_q   <= nz(t_cs);
            end else if (gap_need) begin
              state_q <= S_GAP;
              cnt_q   <= nz(gap_val);
            end else begin
              state_q   <= S_LOW;
              cnt_q     <= nz(t_lo);
              acc_q     <= nz(t_acc);
              sampled_q <= 1'b0;
            end
          end else begin
            ce_n   <= 1'b1;
            last_q <= L_NONE;
          end
        end
        S_SETUP, S_GAP: begin
          if (cnt_q == CW'(1)) begin
            state_q   <= S_LOW;
            cnt_q     <= nz(t_lo);
            acc_q     <= nz(t_acc);
            sampled_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        S_LOW: begin
          if (cnt_q == CW'(1)) begin
            state_q <= S_HIGH;
            cnt_q   <= nz(t_hi);
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        S_HIGH: begin
          if (cnt_q > CW'(1)) cnt_q <= cnt_q - CW'(1);
          if (finish) begin
            state_q <= S_IDLE;
            done    <= 1'b1;
            last_q  <= rd_q ? L_RE : ((kind_q == 2'b01) ? L_ADDR : L_WE);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_cycle_timer_chk.sv
module nand_cycle_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic ce_n,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic dq_oe
);

  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  a_r8_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  a_r3_strobe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_ce_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |-> ($past(req_ready) && !$past(req_valid)));

  a_r9_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  a_r9_read_floats: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);

endmodule

bind nand_cycle_timer nand_cycle_timer_chk u_chk (.*);

// File: tb/tb_nand_cycle_timer.sv
module tb_nand_cycle_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, wide16 = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [31:0] req_wdata = '0;
  logic [7:0] t_lo = 8'd2, t_hi = 8'd2, t_acc = 8'd1, t_w2r = 8'd1,
              t_r2w = 8'd1, t_r2r = 8'd1, t_cs = 8'd1;
  logic [6:0] t_a2d = 7'd1;
  logic [15:0] dq_i = '0;
  logic req_ready, done, ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [31:0] rdata;
  logic [15:0] dq_o;

  int checks = 0, errors = 0;
  int cyc = 0, t_fall = 0, t_rise = 0, t_ce = 0;
  int low_len = 0, gap_meas = 0, setup_meas = 0, ce_rises = 0, k = 0;
  logic fall_cle = 0, fall_ale = 0, cur_s, pstrobe = 0, pce = 1, pre = 1;
  logic [15:0] fall_dq = '0;
  logic [31:0] got = '0;

  always #10 clk = ~clk;

  nand_cycle_timer dut (.*);

  always @(negedge clk) begin
    cyc++;
    cur_s = !(we_n && re_n);
    if (cur_s && !pstrobe) begin
      gap_meas = cyc - t_rise; setup_meas = cyc - t_ce; t_fall = cyc;
      fall_cle = cle; fall_ale = ale; fall_dq = dq_o;
    end
    if (!cur_s && pstrobe) begin t_rise = cyc; low_len = cyc - t_fall; end
    if (!ce_n && pce) t_ce = cyc;
    if (ce_n && !pce) ce_rises++;
    if (!re_n && pre) k = 1; else k++;
    dq_i = {8'(k + 128), 8'(k)};
    pstrobe = cur_s; pce = ce_n; pre = re_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [1:0] kd, input logic w, input logic [31:0] d);
    req_valid = 1'b1; req_kind = kd; req_write = w; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    got = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ce_n", ce_n, 1); chk("R1 we_n", we_n, 1); chk("R1 re_n", re_n, 1);
    chk("R1 cle/ale", {cle, ale}, 0); chk("R1 dq_oe", dq_oe, 0);
    chk("R1 done", done, 0); chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_command;
    t_cs = 3; t_lo = 4; t_hi = 2;
    xfer(2'b00, 1'b0, 32'h0000_0070);
    chk("R3 setup", setup_meas, 3);
    chk("R2 low len", low_len, 4);
    chk("R8 cle at cmd", {fall_cle, fall_ale}, 2'b10);
    chk("R8 cmd byte", fall_dq, 16'h0070);
    idle(2);
    chk("R10 ce released", ce_n, 1);
  endtask

  task automatic t_zero_counts;
    t_cs = 0; t_lo = 0; t_hi = 0;
    xfer(2'b00, 1'b0, 32'h0000_00FF);
    chk("R3 zero setup", setup_meas, 1);
    chk("R2 zero low", low_len, 1);
    xfer(2'b00, 1'b0, 32'h0000_00FE);
    chk("R2 zero high gap", gap_meas, 2);
    idle(2);
  endtask

  task automatic t_addr_data;
    t_cs = 1; t_lo = 2; t_hi = 3; t_a2d = 5; ce_rises = 0;
    xfer(2'b01, 1'b1, 32'h0000_0012);
    chk("R8 ale at addr", {fall_cle, fall_ale}, 2'b01);
    xfer(2'b01, 1'b1, 32'h0000_0034);
    chk("R7 addr to addr no gap", gap_meas, 4);
    xfer(2'b10, 1'b1, 32'h0034_0056);
    chk("R7 addr to data gap", gap_meas, 9);
    chk("R9 8-bit write", fall_dq, 16'h0056);
    chk("R8 data no latch", {fall_cle, fall_ale}, 2'b00);
    chk("R10 ce held", ce_rises, 0);
    idle(2);
  endtask

  task automatic t_write_read;
    t_lo = 3; t_hi = 2; t_w2r = 4; t_acc = 2;
    xfer(2'b10, 1'b1, 32'h0000_00AA);
    xfer(2'b10, 1'b0, 32'h0);
    chk("R5 write to read gap", gap_meas, 7);
    chk("R4 sample point", got, 32'h2);
    chk("R9 8-bit read", got[31:8], 24'h0);
    idle(2);
  endtask

  task automatic t_read_turns;
    t_lo = 2; t_hi = 2; t_r2r = 6; t_r2w = 3; t_acc = 1;
    xfer(2'b10, 1'b0, 32'h0);
    xfer(2'b10, 1'b0, 32'h0);
    chk("R6 read to read gap", gap_meas, 9);
    chk("R4 sample first clock", got, 32'h1);
    xfer(2'b00, 1'b0, 32'h0000_0011);
    chk("R6 read to write gap", gap_meas, 6);
    idle(2);
  endtask

  task automatic t_late_sample;
    t_lo = 2; t_hi = 1; t_acc = 6;
    xfer(2'b10, 1'b0, 32'h0);
    chk("R4 stretched sample", got, 32'h6);
    chk("R2 low unchanged", low_len, 2);
    idle(2);
  endtask

  task automatic t_wide;
    wide16 = 1'b1; t_lo = 2; t_hi = 2; t_acc = 3;
    xfer(2'b00, 1'b0, 32'h00FF_00A5);
    chk("R8 cmd 8-bit in wide", fall_dq, 16'h00A5);
    xfer(2'b10, 1'b1, 32'h1122_3344);
    chk("R9 16-bit write", fall_dq, 16'h2244);
    xfer(2'b10, 1'b0, 32'h0);
    chk("R9 16-bit read", got, 32'h0083_0003);
    wide16 = 1'b0;
    idle(2);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_command;
    t_zero_counts;
    t_addr_data;
    t_write_read;
    t_read_turns;
    t_late_sample;
    t_wide;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule